// File: doc/BRIEF.md
# Two-Wide Issue Packet Gate

This block sits at the front of a statically scheduled, two-wide integer pipeline. Each cycle it can accept one aligned 64-bit fetch packet that carries two 32-bit instructions. The lower-address word (bits 31:0) is slot 0 and must be an ALU operation, a branch or a jump. The upper word (bits 63:32) is slot 1 and must be a load or a store. The all-zero word is a nop and is legal in either slot.

The gate decodes only what it needs: the instruction class, the source registers and the destination register. It finds two hazards that forwarding cannot cover. The first is a slot-1 memory operation that reads a register the slot-0 ALU operation writes in the same packet. The second is an instruction that reads a register loaded by the packet issued just before it. For the first hazard it splits the packet over two cycles. For the second it holds the packet and inserts one empty cycle. If a packet breaks the slot rules, the gate discards it, issues two nops and raises a one-cycle error flag.

A packet is accepted on any rising edge where `pkt_valid` and `pkt_ready` are both high. The issue outputs are registered, so the result of an accepted packet appears on the following cycle.

Top module: `pkt_issue_gate`

## Requirements
- R1: During and directly after synchronous reset, `out_valid` and `bad_pkt` are 0. With no packet offered, `pkt_ready` is 1 and `stall` is 0.
- R2: A legal packet with no hazard is accepted as soon as it is offered. One cycle later it is issued unchanged: `out_slot0` = bits 31:0, `out_slot1` = bits 63:32, `out_valid` = 1.
- R3: A packet breaks the slot rules when slot 0 is not a nop, ALU (opcode 0 or 0x08-0x0F), branch (0x04-0x07) or jump (0x02), or when slot 1 is not a nop, load (0x20, 0x21, 0x23, 0x24, 0x25) or store (0x28, 0x29, 0x2B). Such a packet is accepted at once, even if it would also have a load-use hazard. It is issued as two all-zero words with `bad_pkt` = 1 for that issue cycle.
- R4: The same-packet split applies when slot 1 reads, as base (bits 25:21) or as store data (bits 20:16), the nonzero register written by slot 0. Slot 0 writes bits 15:11 for opcode 0 and bits 20:16 for immediate ALU operations. Such a packet is accepted, then issued as {slot 0, nop}. On the next cycle it is issued as {nop, slot 1}. `pkt_ready` is low during that second cycle.
- R5: Say the last issued word pair had a load in slot 1 that writes a nonzero register (bits 20:16). If either instruction of the offered packet reads that register, `pkt_ready` is low for one cycle, `out_valid` is 0 in the following cycle, and the packet is then accepted.
- R6: Writes to register 0, and instructions with no destination (stores, branches, jumps), never cause a split or a stall.
- R7: `stall` is always the inverse of `pkt_ready`.
- R8: A nop in either slot is legal and never takes part in a hazard.
- R9: Every accepted legal instruction is issued exactly once, in program order.
- R10: When no packet is offered and nothing is held, `out_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pkt_valid | input | 1 | A fetch packet is offered |
| pkt_word | input | 64 | Packet; bits 31:0 slot 0, bits 63:32 slot 1 |
| pkt_ready | output | 1 | Packet accepted on this edge when valid |
| stall | output | 1 | Front end must hold its packet |
| out_valid | output | 1 | An issue pair is present this cycle |
| out_slot0 | output | 32 | Issued ALU/branch word |
| out_slot1 | output | 32 | Issued load/store word |
| bad_pkt | output | 1 | The current issue replaces a rule-breaking packet |

## Verification
The hardest case to reach is a split packet whose held load is then used by the very next packet. In that case the hold cycle and the load-use bubble stack, and the packet waits two cycles. The vector stream places such a packet directly after a split. Its expected wait is counted as the sum of both causes. Two more packets are placed so that two rules meet. One is a rule-breaking packet that reads a just-loaded register; it checks that the error path wins over the stall. The other is a load into register 0 followed by a reader of register 0, which checks that no stall follows.

// File: rtl/dip_pkg.sv
package dip_pkg;

    localparam int IW    = 32;
    localparam int RW    = 5;
    localparam int OPW   = 6;

    localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OP_J     = 6'h02;

    typedef enum logic [2:0] {
        CL_NOP, CL_ALU, CL_BR, CL_LD, CL_ST, CL_BAD
    } iclass_t;

    typedef struct packed {
        iclass_t         cls;
        logic [RW-1:0]   src_a;
        logic            use_a;
        logic [RW-1:0]   src_b;
        logic            use_b;
        logic [RW-1:0]   dst;
        logic            wr;
    } idec_t;

    typedef enum logic [2:0] {
        ACT_IDLE, ACT_PAIR, ACT_SPLIT, ACT_HELD, ACT_BUBBLE, ACT_KILL
    } act_t;

    function automatic logic reads_reg(idec_t d, logic [RW-1:0] r);
        return (d.use_a && d.src_a == r) || (d.use_b && d.src_b == r);
    endfunction

    function automatic logic slot0_ok(iclass_t c);
        return c == CL_NOP || c == CL_ALU || c == CL_BR;
    endfunction

    function automatic logic slot1_ok(iclass_t c);
        return c == CL_NOP || c == CL_LD || c == CL_ST;
    endfunction

endpackage

// File: rtl/dip_slot_decode.sv
module dip_slot_decode
    import dip_pkg::*;
(
    input  logic [IW-1:0] word,
    output idec_t         dec
);
    logic [OPW-1:0] op;
    logic [RW-1:0]  f_rs, f_rt, f_rd;
    logic           unused_low;

    assign op         = word[31:26];
    assign f_rs       = word[25:21];
    assign f_rt       = word[20:16];
    assign f_rd       = word[15:11];
    assign unused_low = ^word[10:0];

    always_comb begin
        dec       = '0;
        dec.cls   = CL_BAD;
        dec.src_a = f_rs;
        dec.src_b = f_rt;
        dec.dst   = '0;
        if (word == '0) begin
            dec.cls = CL_NOP;
        end else begin
            unique casez (op)
                OP_RTYPE: begin
                    dec.cls   = CL_ALU;
                    dec.use_a = 1'b1;
                    dec.use_b = 1'b1;
                    dec.dst   = f_rd;
                end
                6'b001???: begin
                    dec.cls   = CL_ALU;
                    dec.use_a = 1'b1;
                    dec.dst   = f_rt;
                end
                6'b0001??: begin
                    dec.cls   = CL_BR;
                    dec.use_a = 1'b1;
                    dec.use_b = !op[1];
                end
                OP_J: dec.cls = CL_BR;
                6'h20, 6'h21, 6'h23, 6'h24, 6'h25: begin
                    dec.cls   = CL_LD;
                    dec.use_a = 1'b1;
                    dec.dst   = f_rt;
                end
                6'h28, 6'h29, 6'h2B: begin
                    dec.cls   = CL_ST;
                    dec.use_a = 1'b1;
                    dec.use_b = 1'b1;
                end
                default: dec.cls = CL_BAD;
            endcase
        end
        dec.wr = (dec.dst != '0);
    end
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard
    import dip_pkg::*;
(
    input  idec_t d_slot0,
    input  idec_t d_slot1,
    input  idec_t d_prev,
    input  logic  prev_vld,
    output logic  illegal,
    output logic  load_use,
    output logic  intra
);
    always_comb begin
        illegal  = !slot0_ok(d_slot0.cls) || !slot1_ok(d_slot1.cls);
        load_use = prev_vld && d_prev.cls == CL_LD && d_prev.wr &&
                   (reads_reg(d_slot0, d_prev.dst) || reads_reg(d_slot1, d_prev.dst));
        intra    = d_slot0.wr && reads_reg(d_slot1, d_slot0.dst);
    end
endmodule

// File: rtl/dip_issue_ctl.sv
module dip_issue_ctl
    import dip_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          pkt_valid,
    input  logic [2*IW-1:0] pkt_word,
    input  logic          illegal,
    input  logic          load_use,
    input  logic          intra,
    output logic          pkt_ready,
    output logic          hold_vld,
    output logic          out_valid,
    output logic [IW-1:0] out_slot0,
    output logic [IW-1:0] out_slot1,
    output logic          bad_pkt
);
    logic [IW-1:0] hold_word;
    act_t          act;

    always_comb begin
        if (hold_vld)        act = ACT_HELD;
        else if (!pkt_valid) act = ACT_IDLE;
        else if (illegal)    act = ACT_KILL;
        else if (load_use)   act = ACT_BUBBLE;
        else if (intra)      act = ACT_SPLIT;
        else                 act = ACT_PAIR;
        pkt_ready = !(act == ACT_HELD || act == ACT_BUBBLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_vld  <= 1'b0;
            hold_word <= '0;
            out_valid <= 1'b0;
            out_slot0 <= '0;
            out_slot1 <= '0;
            bad_pkt   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_slot0 <= '0;
            out_slot1 <= '0;
            bad_pkt   <= 1'b0;
            hold_vld  <= 1'b0;
            unique case (act)
                ACT_PAIR: begin
                    out_valid <= 1'b1;
                    out_slot0 <= pkt_word[IW-1:0];
                    out_slot1 <= pkt_word[2*IW-1:IW];
                end
                ACT_SPLIT: begin
                    out_valid <= 1'b1;
                    out_slot0 <= pkt_word[IW-1:0];
                    hold_vld  <= 1'b1;
                    hold_word <= pkt_word[2*IW-1:IW];
                end
                ACT_HELD: begin
                    out_valid <= 1'b1;
                    out_slot1 <= hold_word;
                end
                ACT_KILL: begin
                    out_valid <= 1'b1;
                    bad_pkt   <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pkt_issue_gate.sv
module pkt_issue_gate
    import dip_pkg::*;
#(
    parameter int NDEC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pkt_valid,
    input  logic [63:0]   pkt_word,
    output logic          pkt_ready,
    output logic          stall,
    output logic          out_valid,
    output logic [31:0]   out_slot0,
    output logic [31:0]   out_slot1,
    output logic          bad_pkt
);
    logic [IW-1:0] dec_word [NDEC];
    idec_t         dec      [NDEC];
    logic          illegal, load_use, intra, hold_vld;

    // index 0/1: offered slots; index 2: slot 1 of the pair issued last cycle
    assign dec_word[0] = pkt_word[IW-1:0];
    assign dec_word[1] = pkt_word[2*IW-1:IW];
    assign dec_word[2] = out_valid ? out_slot1 : '0;

    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        dip_slot_decode u_dec (.word(dec_word[g]), .dec(dec[g]));
    end

    dip_hazard u_haz (
        .d_slot0 (dec[0]),
        .d_slot1 (dec[1]),
        .d_prev  (dec[2]),
        .prev_vld(out_valid),
        .illegal (illegal),
        .load_use(load_use),
        .intra   (intra)
    );

    dip_issue_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .pkt_valid(pkt_valid),
        .pkt_word (pkt_word),
        .illegal  (illegal),
        .load_use (load_use),
        .intra    (intra),
        .pkt_ready(pkt_ready),
        .hold_vld (hold_vld),
        .out_valid(out_valid),
        .out_slot0(out_slot0),
        .out_slot1(out_slot1),
        .bad_pkt  (bad_pkt)
    );

    assign stall = !pkt_ready;
endmodule

// File: rtl/pkt_issue_gate_chk.sv
module pkt_issue_gate_chk (
    input logic        clk,
    input logic        rst,
    input logic        pkt_valid,
    input logic        pkt_ready,
    input logic        hold_vld,
    input logic        out_valid,
    input logic [31:0] out_slot0,
    input logic [31:0] out_slot1,
    input logic        bad_pkt
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !bad_pkt));

    assert_accept_issues_R2: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_ready) |=> out_valid);

    assert_kill_zero_R3: assert property (@(posedge clk) disable iff (rst)
        bad_pkt |-> (out_valid && out_slot0 == 32'd0 && out_slot1 == 32'd0));

    assert_held_issue_R4: assert property (@(posedge clk) disable iff (rst)
        hold_vld |=> (out_valid && out_slot0 == 32'd0 && !hold_vld));

    assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready && !hold_vld) |=> !out_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!pkt_valid && !hold_vld) |=> !out_valid);
endmodule

bind pkt_issue_gate pkt_issue_gate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready),
    .hold_vld (hold_vld),
    .out_valid(out_valid),
    .out_slot0(out_slot0),
    .out_slot1(out_slot1),
    .bad_pkt  (bad_pkt)
);

// File: tb/pkt_issue_gate_test.sv
module pkt_issue_gate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_valid = 1'b0;
    logic [63:0] pkt_word = '0;
    logic        pkt_ready, stall, out_valid, bad_pkt;
    logic [31:0] out_slot0, out_slot1;

    always #2.5 clk = ~clk;

    pkt_issue_gate uut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_word(pkt_word),
        .pkt_ready(pkt_ready), .stall(stall), .out_valid(out_valid),
        .out_slot0(out_slot0), .out_slot1(out_slot1), .bad_pkt(bad_pkt)
    );

    localparam logic [1:0] M_N = 2'd0;  // plain pair
    localparam logic [1:0] M_S = 2'd1;  // same-packet split
    localparam logic [1:0] M_L = 2'd2;  // load-use bubble
    localparam logic [1:0] M_I = 2'd3;  // rule violation

    function automatic logic [31:0] rr(input logic [4:0] rd, input logic [4:0] rs,
                                       input logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'h00, 6'h21};
    endfunction

    function automatic logic [31:0] ii(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [4:0] rs);
        return {op, rs, rt, 16'h0004};
    endfunction

    localparam int NV = 18;
    // {mode, slot0, slot1}
    localparam logic [65:0] VEC [NV] = '{
        {M_N, rr(8, 9, 10),       ii(6'h23, 11, 12)},
        {M_L, rr(18, 11, 1),      32'h0},
        {M_N, ii(6'h0D, 2, 3),    ii(6'h23, 4, 5)},
        {M_L, 32'h0,              ii(6'h2B, 6, 4)},
        {M_S, rr(7, 1, 2),        ii(6'h23, 9, 7)},
        {M_L, rr(20, 9, 0),       32'h0},
        {M_S, ii(6'h0D, 21, 0),   ii(6'h2B, 21, 1)},
        {M_N, rr(0, 1, 2),        ii(6'h23, 0, 5)},
        {M_N, rr(1, 0, 0),        ii(6'h2B, 2, 3)},
        {M_N, ii(6'h04, 2, 1),    ii(6'h2B, 1, 2)},
        {M_I, ii(6'h23, 1, 2),    32'h0},
        {M_I, rr(1, 2, 3),        rr(4, 5, 6)},
        {M_N, 32'h0,              32'h0},
        {M_N, rr(5, 6, 7),        ii(6'h23, 8, 9)},
        {M_I, ii(6'h2B, 1, 8),    32'h0},
        {M_N, 32'h0,              ii(6'h23, 10, 11)},
        {M_N, rr(1, 2, 3),        32'h0},
        {M_I, ii(6'h03, 0, 0),    32'h0}
    };

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] exp_s0 [64];
    logic [31:0] exp_s1 [64];
    logic        exp_bad[64];
    int exp_n = 0;
    int got_n = 0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] b, input logic e);
        exp_s0[exp_n]  = a;
        exp_s1[exp_n]  = b;
        exp_bad[exp_n] = e;
        exp_n++;
    endtask

    // issue monitor: compares each issued pair with the expected order (R9)
    always @(negedge clk) begin
        if (!rst) begin
            if (bad_pkt && !out_valid)
                chk(1'b0, "R3 flag without issue", 64'(bad_pkt), 64'd0);
            if (out_valid) begin
                if (got_n >= exp_n) begin
                    chk(1'b0, "R9 unexpected issue", {out_slot1, out_slot0}, 64'd0);
                end else begin
                    chk({out_slot1, out_slot0, bad_pkt} ==
                        {exp_s1[got_n], exp_s0[got_n], exp_bad[got_n]},
                        "R2/R3/R4/R9 issued pair",
                        {out_slot1, out_slot0},
                        {exp_s1[got_n], exp_s0[got_n]});
                end
                got_n++;
            end
        end
    end

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd20000);
            finish_up();
        end
    end

    initial begin
        logic [1:0] prev_mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(!out_valid && !bad_pkt, "R1 reset outputs", {62'd0, out_valid, bad_pkt}, 64'd0);
        chk(pkt_ready && !stall, "R1 ready after reset", {62'd0, pkt_ready, stall}, 64'd2);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!out_valid && !bad_pkt, "R1 first cycle after reset",
            {62'd0, out_valid, bad_pkt}, 64'd0);
        chk(pkt_ready && !stall, "R1 idle ready", {62'd0, pkt_ready, stall}, 64'd2);

        prev_mode = M_N;
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  m;
            logic [31:0] s0, s1;
            int waits, exp_w;
            m  = VEC[i][65:64];
            s0 = VEC[i][63:32];
            s1 = VEC[i][31:0];
            case (m)
                M_S:     begin push(s0, 32'h0, 1'b0); push(32'h0, s1, 1'b0); end
                M_I:     push(32'h0, 32'h0, 1'b1);
                default: push(s0, s1, 1'b0);
            endcase
            exp_w = ((m == M_L) ? 1 : 0) + ((prev_mode == M_S) ? 1 : 0);
            pkt_valid = 1'b1;
            pkt_word  = {s1, s0};
            waits = 0;
            forever begin
                #1;
                chk(stall == !pkt_ready, "R7 stall polarity",
                    {62'd0, stall, pkt_ready}, {62'd0, !pkt_ready, pkt_ready});
                if (pkt_ready) break;
                waits++;
                @(negedge clk);
            end
            // R4 hold cycle, R5 bubble, R6/R8 no wait, R3 illegal wins
            chk(waits == exp_w, $sformatf("R4/R5/R6/R8 wait count vector %0d", i),
                64'(waits), 64'(exp_w));
            prev_mode = m;
            @(negedge clk);
        end
        pkt_valid = 1'b0;
        pkt_word  = '0;

        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            #1;
            chk(!out_valid, "R10 idle no issue", 64'(out_valid), 64'd0);
        end
        chk(got_n == exp_n, "R9 each instruction issued once", 64'(got_n), 64'(exp_n));
        finish_up();
    end
endmodule